// File: doc/BRIEF.md
# Prioritized UART Interrupt Identifier

This block sits between the status sources of a UART channel and the processor. It takes four interrupt request conditions (receiver line status, receive data ready or receive timeout, transmit holding register empty, modem status), masks them with a 4-bit enable register, and produces one active-high interrupt pin. It also produces the 8-bit identification value that software reads to learn which source to service first.

The receive request comes from the receive FIFO fill count. In FIFO mode it is compared against a selectable trigger level. Otherwise any stored character raises it. The transmit-empty request is event based. It is latched when the holding register becomes empty, and it is dropped either by a write to the holding register or by an identification read that reported it. An identification read captures the value at the first cycle of the read strobe and holds it while the strobe stays high.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset `irq` is 0, `isr_val` reads 0x01 (FIFO mode off), and `en_rdata` reads 0x00.
- R2: A write with `en_wr` stores `en_wdata[3:0]` as the enable bits. Bit 0 enables receive data/timeout, bit 1 transmit empty, bit 2 line status, bit 3 modem status. `en_rdata[7:4]` always reads 0.
- R3: `isr_val[0]` is 0 when any enabled source is pending and 1 otherwise. `irq` is 1 exactly when an enabled source is pending.
- R4: Codes in `isr_val[3:0]`, highest priority first: line status 0110, receive data 0100 or receive timeout 1100, transmit empty 0010, modem status 0000. The highest-priority enabled pending source is reported. With none pending the nibble is 0001.
- R5: The receive data request is `rx_count != 0` when FIFO mode is off. With FIFO mode on it is `rx_count >= T`, where `trig_sel` 0,1,2,3 gives T = 1, DEPTH/4, DEPTH/2, DEPTH-2. It drops as soon as the count falls below T.
- R6: Code 1100 is reported only in FIFO mode, with `rx_timeout` high, `rx_count` nonzero and below T. When both the data and timeout conditions hold, 0100 is reported.
- R7: The transmit-empty request is set one cycle after a rising edge of `thr_empty`. It is also set one cycle after enable bit 1 goes from 0 to 1 while `thr_empty` is high.
- R8: The transmit-empty request is cleared one cycle after a `thr_wr` pulse. It is also cleared after a read start that returned code 0010. A set condition in the same cycle takes precedence.
- R9: `isr_val[7:6]` both equal `fifo_en`. `isr_val[5:4]` are always 0.
- R10: On the first cycle of `isr_rd` high, `isr_val` shows the live value and that value is captured. `isr_val` then stays at the captured value for as long as `isr_rd` remains high, whatever the sources do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| en_rdata | output | 8 | Enable register read value |
| ls_req | input | 1 | Receiver line status condition |
| rx_count | input | CNT_W (5) | Receive FIFO fill count |
| trig_sel | input | 2 | Receive trigger level select |
| rx_timeout | input | 1 | Receive timeout condition |
| thr_empty | input | 1 | Transmit holding register empty level |
| thr_wr | input | 1 | Transmit holding register write pulse |
| modem_req | input | 1 | Modem status change condition |
| fifo_en | input | 1 | FIFO mode enabled |
| isr_rd | input | 1 | Identification read strobe (level) |
| irq | output | 1 | Interrupt output, active high |
| isr_val | output | 8 | Interrupt identification value |

## Verification
The bench builds the block with the default DEPTH of 16. That makes the four trigger levels 1, 4, 8 and 14 and the count range 0 to 16, so every threshold can be approached from both sides, including a full FIFO. Random counts, trigger selects, source levels, enable writes and read strobes of varied length are compared each cycle against a bench model. Directed cases pin the priority order, the timeout code outside FIFO mode and a source change during a held read.

// File: rtl/uart_irq_pkg.sv
// Package: identification codes and trigger-level computation shared by
// the interrupt identifier. Assumes DEPTH is a multiple of 4 and >= 4.
package uart_irq_pkg;

    // identity bits [3:1] of the status value, one per source
    typedef enum logic [2:0] {
        ID_MODEM   = 3'b000,
        ID_TXEMPTY = 3'b001,
        ID_RXDATA  = 3'b010,
        ID_LINE    = 3'b011,
        ID_RXTOUT  = 3'b110
    } irq_id_e;

    // trigger threshold for a given select value and FIFO depth
    function automatic int unsigned trig_level(input logic [1:0] sel,
                                               input int unsigned depth);
        case (sel)
            2'd0:    return 1;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_rx_req.sv
// Receive request decode: turns the FIFO fill count into a data-ready
// request and a qualified timeout request. Purely combinational.
// Assumes rx_count never exceeds DEPTH.
module uart_irq_rx_req #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] rx_count,
    input  logic [1:0]       trig_sel,
    input  logic             fifo_en,
    input  logic             rx_timeout,
    output logic             data_req,
    output logic             tout_req
);
    import uart_irq_pkg::*;

    logic [CNT_W-1:0] thresh;
    logic             nonempty;

    // threshold selected from the trigger code
    always_comb thresh = CNT_W'(trig_level(trig_sel, DEPTH));

    // data request by mode, timeout only when data is below the threshold
    always_comb begin
        nonempty = (rx_count != '0);
        data_req = fifo_en ? (rx_count >= thresh) : nonempty;
        tout_req = fifo_en && rx_timeout && nonempty && !data_req;
    end

endmodule

// File: rtl/uart_irq_tx_track.sv
// Transmit-empty request latch. Sets on a rising edge of the holding-empty
// level or when the transmit enable rises while empty; clears on a holding
// register write or a read that reported this source. Set wins.
module uart_irq_tx_track (
    input  logic clk,
    input  logic rst_n,
    input  logic thr_empty,
    input  logic thr_wr,
    input  logic en_tx,
    input  logic rd_clear,
    output logic tx_pend
);
    logic empty_q;
    logic en_q;
    logic set_c;
    logic clr_c;

    // edge conditions for set and clear
    always_comb begin
        set_c = (thr_empty && !empty_q) || (en_tx && !en_q && thr_empty);
        clr_c = thr_wr || rd_clear;
    end

    // history registers and pending flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_q <= 1'b0;
            en_q    <= 1'b0;
            tx_pend <= 1'b0;
        end else begin
            empty_q <= thr_empty;
            en_q    <= en_tx;
            if (set_c)      tx_pend <= 1'b1;
            else if (clr_c) tx_pend <= 1'b0;
        end
    end

    AST_TX_SET_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_empty && !empty_q) |=> tx_pend); // R7

    AST_TX_CLR_ON_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr && !thr_empty) |=> !tx_pend); // R8

endmodule

// File: rtl/uart_irq_prio.sv
// Priority encoder: masks the four requests with the enable bits and forms
// the live identification value. Purely combinational.
module uart_irq_prio (
    input  logic [3:0] en,
    input  logic       ls_req,
    input  logic       data_req,
    input  logic       tout_req,
    input  logic       tx_pend,
    input  logic       modem_req,
    input  logic       fifo_en,
    output logic       pending,
    output logic [7:0] live
);
    import uart_irq_pkg::*;

    irq_id_e id;

    // highest enabled source selects the identity bits
    always_comb begin
        pending = 1'b1;
        id      = ID_MODEM;
        if (en[2] && ls_req)          id = ID_LINE;
        else if (en[0] && data_req)   id = ID_RXDATA;
        else if (en[0] && tout_req)   id = ID_RXTOUT;
        else if (en[1] && tx_pend)    id = ID_TXEMPTY;
        else if (en[3] && modem_req)  id = ID_MODEM;
        else                          pending = 1'b0;
        live = {fifo_en, fifo_en, 2'b00, id, !pending};
    end

    AST_LINE_WINS: assert final (!(en[2] && ls_req) || live[3:0] == 4'b0110); // R4

endmodule

// File: rtl/uart_irq_ident.sv
// Top of the interrupt identifier: enable register, receive and transmit
// request logic, priority encoder and read-capture of the status value.
// Assumes isr_rd is a level held for the whole read access.
module uart_irq_ident #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_wr,
    input  logic [7:0]       en_wdata,
    output logic [7:0]       en_rdata,
    input  logic             ls_req,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [1:0]       trig_sel,
    input  logic             rx_timeout,
    input  logic             thr_empty,
    input  logic             thr_wr,
    input  logic             modem_req,
    input  logic             fifo_en,
    input  logic             isr_rd,
    output logic             irq,
    output logic [7:0]       isr_val
);
    logic [3:0] en_q;
    logic       data_req;
    logic       tout_req;
    logic       tx_pend;
    logic       pending;
    logic [7:0] live;
    logic       rd_q;
    logic [7:0] held;
    logic       rd_start;
    logic       rd_clear;

    // enable register storage
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= en_wdata[3:0];
    end

    // enable register read value with zero upper bits
    always_comb en_rdata = {4'b0000, en_q};

    uart_irq_rx_req #(.DEPTH(DEPTH)) rx_i (
        .rx_count   (rx_count),
        .trig_sel   (trig_sel),
        .fifo_en    (fifo_en),
        .rx_timeout (rx_timeout),
        .data_req   (data_req),
        .tout_req   (tout_req)
    );

    // read start and transmit-clear qualification
    always_comb begin
        rd_start = isr_rd && !rd_q;
        rd_clear = rd_start && (live[3:0] == 4'b0010);
    end

    uart_irq_tx_track tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .thr_empty (thr_empty),
        .thr_wr    (thr_wr),
        .en_tx     (en_q[1]),
        .rd_clear  (rd_clear),
        .tx_pend   (tx_pend)
    );

    uart_irq_prio prio_i (
        .en        (en_q),
        .ls_req    (ls_req),
        .data_req  (data_req),
        .tout_req  (tout_req),
        .tx_pend   (tx_pend),
        .modem_req (modem_req),
        .fifo_en   (fifo_en),
        .pending   (pending),
        .live      (live)
    );

    // read strobe history and captured value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= 1'b0;
            held <= 8'h01;
        end else begin
            rd_q <= isr_rd;
            if (rd_start) held <= live;
        end
    end

    // output selection: captured during a read, live otherwise
    always_comb begin
        isr_val = rd_q ? held : live;
        irq     = pending;
    end

    AST_HOLD_DURING_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_rd && rd_q) |=> $stable(isr_val)); // R10

    AST_IRQ_LOW_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == 4'b0000) |-> !irq); // R3

    AST_TX_CLEARED_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && live[3:0] == 4'b0010 && !thr_empty) |=> !tx_pend); // R8

endmodule

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb_top;
    localparam int unsigned DEPTH = 16;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam time CLK_PERIOD = 10ns;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             en_wr;
    logic [7:0]       en_wdata;
    logic [7:0]       en_rdata;
    logic             ls_req;
    logic [CNT_W-1:0] rx_count;
    logic [1:0]       trig_sel;
    logic             rx_timeout;
    logic             thr_empty;
    logic             thr_wr;
    logic             modem_req;
    logic             fifo_en;
    logic             isr_rd;
    logic             irq;
    logic [7:0]       isr_val;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // bench model state
    logic [3:0] m_en;
    logic       m_txp, m_empty_q, m_en_q, m_rd_q;
    logic [7:0] m_held;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_irq_ident #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
        .en_rdata(en_rdata), .ls_req(ls_req), .rx_count(rx_count),
        .trig_sel(trig_sel), .rx_timeout(rx_timeout), .thr_empty(thr_empty),
        .thr_wr(thr_wr), .modem_req(modem_req), .fifo_en(fifo_en),
        .isr_rd(isr_rd), .irq(irq), .isr_val(isr_val)
    );

    function automatic int unsigned exp_trig(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return DEPTH / 4;
            2'd2: return DEPTH / 2;
            default: return DEPTH - 2;
        endcase
    endfunction

    // live status value from the requirements
    function automatic logic [7:0] exp_live();
        logic dr, to;
        logic [3:0] nib;
        dr = fifo_en ? (int'(rx_count) >= int'(exp_trig(trig_sel))) : (rx_count != 0);
        to = fifo_en && rx_timeout && (rx_count != 0) && !dr;
        if (m_en[2] && ls_req)         nib = 4'b0110;
        else if (m_en[0] && dr)        nib = 4'b0100;
        else if (m_en[0] && to)        nib = 4'b1100;
        else if (m_en[1] && m_txp)     nib = 4'b0010;
        else if (m_en[3] && modem_req) nib = 4'b0000;
        else                           nib = 4'b0001;
        return {fifo_en, fifo_en, 2'b00, nib};
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // one cycle: compare at negedge, advance model at posedge
    task automatic cyc(input string tag);
        logic [7:0] lv, ev;
        logic rs, setc;
        @(negedge clk);
        lv = exp_live();
        ev = m_rd_q ? m_held : lv;
        check8(tag, isr_val, ev);
        n_checks++;
        if (irq !== !lv[0]) begin
            n_fail++;
            $display("FAIL R3 irq actual %b expected %b", irq, !lv[0]);
        end
        @(posedge clk);
        rs   = isr_rd && !m_rd_q;
        setc = (thr_empty && !m_empty_q) || (m_en[1] && !m_en_q && thr_empty);
        if (setc) m_txp = 1'b1;
        else if (thr_wr || (rs && lv[3:0] == 4'b0010)) m_txp = 1'b0;
        if (rs) m_held = lv;
        m_empty_q = thr_empty;
        m_en_q    = m_en[1];
        m_rd_q    = isr_rd;
        if (en_wr) m_en = en_wdata[3:0];
        #1;
    endtask

    task automatic idle_inputs();
        en_wr = 0; en_wdata = 0; ls_req = 0; rx_count = 0; trig_sel = 0;
        rx_timeout = 0; thr_empty = 0; thr_wr = 0; modem_req = 0;
        fifo_en = 0; isr_rd = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'h5EED_1234;
        void'($urandom(seed));
        idle_inputs();
        rst_n = 0;
        m_en = 0; m_txp = 0; m_empty_q = 0; m_en_q = 0; m_rd_q = 0; m_held = 8'h01;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check8("R1 isr", isr_val, 8'h01);
        check8("R1 irq", {7'd0, irq}, 8'h00);
        check8("R1 en", en_rdata, 8'h00);
        @(posedge clk); #1;

        // R2 enable register write
        en_wr = 1; en_wdata = 8'hFF; cyc("R2");
        en_wr = 0;
        @(negedge clk); check8("R2 upper zero", en_rdata, 8'h0F);
        @(posedge clk); #1;

        // R4 priority: line status over modem
        modem_req = 1; cyc("R4 modem");
        check8("R4 modem code", isr_val, 8'h00);
        ls_req = 1; cyc("R4 line");
        check8("R4 line code", isr_val, 8'h06);
        ls_req = 0; modem_req = 0;

        // R5/R6/R9 FIFO thresholds and timeout
        fifo_en = 1; trig_sel = 2'd1; rx_count = 3; rx_timeout = 1;
        cyc("R6 timeout");
        check8("R6 timeout code", isr_val, 8'hCC);
        rx_count = 4; cyc("R5 trigger reached");
        check8("R9 data code fifo", isr_val, 8'hC4);
        rx_count = 0; cyc("R6 empty no timeout");
        check8("R6 empty", isr_val, 8'hC1);
        fifo_en = 0; rx_count = 0; cyc("R6 non-fifo no timeout");
        check8("R9 non-fifo", isr_val, 8'h01);
        rx_timeout = 0;
        fifo_en = 1; trig_sel = 2'd3; rx_count = 13; cyc("R5 below 14");
        rx_count = 14; cyc("R5 at 14");
        rx_count = 0; fifo_en = 0;

        // R7/R8 transmit empty latch and clears
        thr_empty = 1; cyc("R7 rise");
        cyc("R7 pending");
        check8("R7 tx code", isr_val, 8'h02);
        isr_rd = 1; cyc("R10 read start");
        ls_req = 1; cyc("R10 held");
        check8("R10 held code", isr_val, 8'h02);
        isr_rd = 0; cyc("R8 after read");
        check8("R8 cleared by read", isr_val, 8'h06);
        ls_req = 0; thr_empty = 0; cyc("R8 idle");
        thr_empty = 1; cyc("R7 rise 2");
        thr_wr = 1; thr_empty = 0; cyc("R8 write");
        thr_wr = 0; cyc("R8 cleared by write");
        check8("R8 write clear", isr_val, 8'h01);
        // R7 enable rise while empty
        en_wr = 1; en_wdata = 8'h00; thr_empty = 1; cyc("R7 en off");
        en_wr = 0; cyc("R7 set while masked");
        isr_rd = 0; thr_wr = 1; cyc("R8 drop");
        thr_wr = 0; en_wr = 1; en_wdata = 8'h02; cyc("R7 en write");
        en_wr = 0; cyc("R7 en rise"); cyc("R7 en pending");
        check8("R7 enable rise", isr_val, 8'h02);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            ls_req     = ($urandom % 8) == 0;
            modem_req  = ($urandom % 4) == 0;
            rx_count   = CNT_W'($urandom % (DEPTH + 1));
            trig_sel   = 2'($urandom);
            rx_timeout = $urandom % 2;
            fifo_en    = ($urandom % 3) != 0;
            thr_empty  = ($urandom % 3) != 0;
            thr_wr     = ($urandom % 6) == 0;
            en_wr      = ($urandom % 10) == 0;
            en_wdata   = 8'($urandom);
            if (($urandom % 4) == 0) isr_rd = !isr_rd;
            cyc("R4 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule